// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and raises exactly one of three relation flags: greater, equal or less. The word is split into 4-bit slices. Each slice works out its own relation and also takes in the relation already found by the next lower slice. The slices are chained from the least significant to the most significant, and the top slice gives the final answer. The block is purely combinational.

The chain's lowest cascade inputs are brought out to the ports. Driving them with "equal" gives a plain compare. Driving them with the outputs of another comparator extends the compare to a still wider word. The word width is a parameter and must be a multiple of 4.

Top module: `cmp_chain`

## Requirements
- R1: `gt_o` is high exactly when A > B unsigned, or when A == B and `casc_gt_i` is high.
- R2: `lt_o` is high exactly when A < B unsigned, or when A == B and `casc_lt_i` is high.
- R3: `eq_o` is high exactly when A == B and `casc_eq_i` is high; a slice's equality is the AND of its bitwise XNORs.
- R4: When A != B the cascade inputs are ignored. All eight patterns of {`casc_gt_i`,`casc_eq_i`,`casc_lt_i`} give the same outputs.
- R5: When A == B the outputs copy the cascade inputs bit for bit. This holds for patterns that are not one-hot, such as all low (000) or all high (111).
- R6: Whenever exactly one cascade input is high, exactly one of `gt_o`, `eq_o`, `lt_o` is high.
- R7: The most significant slice whose operands differ decides the result. Lower slices cannot override it. With WIDTH=8, 0x80 against 0x7F gives greater, and 0x18 against 0x17 gives greater.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| casc_gt_i | input | 1 | Lower-order relation: greater |
| casc_eq_i | input | 1 | Lower-order relation: equal (tie high when standalone) |
| casc_lt_i | input | 1 | Lower-order relation: less |
| gt_o | output | 1 | A greater than B |
| eq_o | output | 1 | A equal to B |
| lt_o | output | 1 | A less than B |

## Verification
Every pair of 8-bit operands is applied with the cascade set to equal. This separates an error in any slice's bit ordering or any break in the link between slices from a correct compare. Equal operands are then applied with all eight cascade patterns, which shows whether the inputs are passed through unchanged, including the non-one-hot patterns 000 and 111. A sweep of unequal pairs under every cascade pattern shows that the cascade cannot leak into a decided result. Directed vectors in which the two slices pull in opposite directions confirm that the upper slice takes precedence.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;
endpackage

// File: rtl/cmp_eq_detect.sv
module cmp_eq_detect #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  logic [W-1:0] bit_match;

  for (genvar i = 0; i < W; i++) begin : g_xnor
    assign bit_match[i] = ~(a_i[i] ^ b_i[i]);
  end

  assign eq_o = &bit_match;
endmodule

// File: rtl/cmp_gt_detect.sv
module cmp_gt_detect #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  // Scan from the MSB; the first differing bit decides.
  always_comb begin
    logic decided;
    gt_o    = 1'b0;
    decided = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!decided && (a_i[i] != b_i[i])) begin
        gt_o    = a_i[i];
        decided = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  rel_t         casc_i,
  output rel_t         rel_o
);
  logic local_eq;
  logic local_gt;

  cmp_eq_detect #(.W(W)) i_eq (.a_i(a_i), .b_i(b_i), .eq_o(local_eq));
  cmp_gt_detect #(.W(W)) i_gt (.a_i(a_i), .b_i(b_i), .gt_o(local_gt));

  // Own operands decide; cascade passes only on a local tie.
  always_comb begin
    if (local_eq) begin
      rel_o = casc_i;
    end else begin
      rel_o.gt = local_gt;
      rel_o.eq = 1'b0;
      rel_o.lt = ~local_gt;
    end
  end
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             casc_gt_i,
  input  logic             casc_eq_i,
  input  logic             casc_lt_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);
  localparam int unsigned N_SLICES = WIDTH / SLICE_W;

  initial begin
    if ((WIDTH % SLICE_W) != 0 || WIDTH == 0) $error("cmp_chain: WIDTH must be a nonzero multiple of 4");
  end

  rel_t link [N_SLICES+1];

  assign link[0] = '{gt: casc_gt_i, eq: casc_eq_i, lt: casc_lt_i};

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    cmp_slice #(.W(SLICE_W)) i_slice (
      .a_i    (a_i[s*SLICE_W +: SLICE_W]),
      .b_i    (b_i[s*SLICE_W +: SLICE_W]),
      .casc_i (link[s]),
      .rel_o  (link[s+1])
    );
  end

  assign gt_o = link[N_SLICES].gt;
  assign eq_o = link[N_SLICES].eq;
  assign lt_o = link[N_SLICES].lt;
endmodule

// File: rtl/cmp_chain_chk.sv
module cmp_chain_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             casc_gt_i,
  input logic             casc_eq_i,
  input logic             casc_lt_i,
  input logic             gt_o,
  input logic             eq_o,
  input logic             lt_o
);
  always_comb begin
    assert_gt_rule_R1: assert (gt_o == ((a_i > b_i) || ((a_i == b_i) && casc_gt_i)))
      else $error("gt_o mismatch");
    assert_lt_rule_R2: assert (lt_o == ((a_i < b_i) || ((a_i == b_i) && casc_lt_i)))
      else $error("lt_o mismatch");
    assert_eq_rule_R3: assert (eq_o == ((a_i == b_i) && casc_eq_i))
      else $error("eq_o mismatch");
    if (a_i == b_i) begin
      assert_passthru_R5: assert ({gt_o, eq_o, lt_o} == {casc_gt_i, casc_eq_i, casc_lt_i})
        else $error("cascade not passed through");
    end
    if ($countones({casc_gt_i, casc_eq_i, casc_lt_i}) == 1) begin
      assert_onehot_R6: assert ($countones({gt_o, eq_o, lt_o}) == 1)
        else $error("outputs not one-hot");
    end
  end
endmodule

bind cmp_chain cmp_chain_chk #(.WIDTH(WIDTH)) i_cmp_chain_chk (
  .a_i(a_i), .b_i(b_i),
  .casc_gt_i(casc_gt_i), .casc_eq_i(casc_eq_i), .casc_lt_i(casc_lt_i),
  .gt_o(gt_o), .eq_o(eq_o), .lt_o(lt_o)
);

// File: tb/test_cmp_chain.sv
module test_cmp_chain;
  localparam int unsigned WIDTH      = 8;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned VEC_W      = 2*WIDTH + 6;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [WIDTH-1:0] a, b;
  logic [2:0]       casc;
  logic             gt, eq, lt;
  int               checks = 0;
  int               errors = 0;
  bit               done   = 1'b0;

  cmp_chain #(.WIDTH(WIDTH)) i_cmp_chain (
    .a_i(a), .b_i(b),
    .casc_gt_i(casc[2]), .casc_eq_i(casc[1]), .casc_lt_i(casc[0]),
    .gt_o(gt), .eq_o(eq), .lt_o(lt)
  );

  // {a, b, cascade{gt,eq,lt}, expected{gt,eq,lt}}
  localparam logic [VEC_W-1:0] VECS [12] = '{
    {8'h00, 8'h00, 3'b010, 3'b010},  // R3
    {8'hFF, 8'h00, 3'b010, 3'b100},  // R1
    {8'h00, 8'hFF, 3'b010, 3'b001},  // R2
    {8'h5A, 8'h5A, 3'b100, 3'b100},  // R5
    {8'h5A, 8'h5A, 3'b001, 3'b001},  // R5
    {8'h80, 8'h7F, 3'b010, 3'b100},  // R7
    {8'h1F, 8'h20, 3'b010, 3'b001},  // R7
    {8'h18, 8'h17, 3'b010, 3'b100},  // R7
    {8'h34, 8'h3C, 3'b100, 3'b001},  // R4
    {8'h3C, 8'h34, 3'b001, 3'b100},  // R4
    {8'hA5, 8'hA5, 3'b000, 3'b000},  // R5
    {8'hA5, 8'hA5, 3'b111, 3'b111}   // R5
  };

  task automatic apply_check(input logic [WIDTH-1:0] av, input logic [WIDTH-1:0] bv,
                             input logic [2:0] cv, input logic [2:0] exp, input string req);
    @(negedge clk);
    a = av; b = bv; casc = cv;
    @(posedge clk);
    #1;
    checks++;
    if ({gt, eq, lt} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h casc=%b actual=%b expected=%b", req, av, bv, cv, {gt, eq, lt}, exp);
    end
  endtask

  function automatic logic [2:0] ref_rel(input logic [WIDTH-1:0] av, input logic [WIDTH-1:0] bv,
                                         input logic [2:0] cv);
    if (av > bv)      return 3'b100;
    else if (av < bv) return 3'b001;
    else              return cv;
  endfunction

  initial begin
    a = '0; b = '0; casc = 3'b010;
    // Initial state: zero operands, equal cascade
    apply_check('0, '0, 3'b010, 3'b010, "R3");
    foreach (VECS[i]) begin
      apply_check(VECS[i][VEC_W-1 -: WIDTH], VECS[i][VEC_W-WIDTH-1 -: WIDTH],
                  VECS[i][5:3], VECS[i][2:0], "R1/R2/R3 table");
    end
    // R1 R2 R3 R6 R7: exhaustive with equal cascade
    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 256; bi++) begin
        apply_check(ai[7:0], bi[7:0], 3'b010, ref_rel(ai[7:0], bi[7:0], 3'b010), "R1_R2_R3_R7");
      end
    end
    // R5: ties pass every cascade pattern
    for (int ci = 0; ci < 8; ci++) begin
      apply_check(8'hC3, 8'hC3, ci[2:0], ci[2:0], "R5");
    end
    // R4 R6: unequal pairs ignore every cascade pattern
    for (int k = 0; k < 64; k++) begin
      logic [7:0] av = 8'(k * 37 + 5);
      logic [7:0] bv = 8'(k * 91 + 2);
      for (int ci = 0; ci < 8; ci++) begin
        apply_check(av, bv, ci[2:0], ref_rel(av, bv, ci[2:0]), "R4");
      end
    end
    // R6: one-hot cascade, equal operands
    apply_check(8'h00, 8'h00, 3'b100, 3'b100, "R6");
    apply_check(8'hFF, 8'hFF, 3'b001, 3'b001, "R6");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule